// File: doc/BRIEF.md
# Multi-Context Dual-Issue Thread Scheduler

This block chooses, on every clock, which hardware execution contexts of a heavily multithreaded core issue instructions. The core keeps state for many contexts and has four independent sets of execution resources, called issue slots. Each context reports whether it is ready, and it describes its next two pending instructions. For each of these it gives a valid flag. For the second instruction it also gives whether it is arithmetic and whether it depends on the first.

The contexts are split into equal fixed groups, one group per slot. Each slot runs its own round-robin search over its group and picks one eligible context. It then decides whether that context issues one instruction or two. A second instruction is paired only when it is valid, non-arithmetic (a load or store, for example) and independent of the first. The selected context IDs, the per-slot issue counts and a one-hot acknowledge per context are all registered. They appear the cycle after the inputs they were computed from.

Top module: `ctx_issue_sched`

## Requirements
- R1: While `rst_n` is low at a rising edge, every `slot_valid`, `slot_cnt` and `ctx_grant` bit is 0 on the next cycle. The round-robin position of every slot returns to the first context of its group, so the first pick after reset is the lowest eligible context of that group.
- R2: Slot s only selects contexts s*16 to s*16+15. `slot_ctx` carries the global 6-bit context number in bits [6s+5:6s].
- R3: A context is eligible only when its `ctx_ready` bit and its `ins0_valid` bit are both 1. An ineligible context is skipped and is never granted.
- R4: Each slot searches its group starting one position after the context it last granted, wrapping within the group, and takes the first eligible context found.
- R5: `slot_cnt` for a valid slot (2 bits at [2s+1:2s]) is 2 when the chosen context's second instruction is valid, non-arithmetic and independent. Otherwise it is 1.
- R6: A slot whose group has no eligible context outputs `slot_valid` = 0 and `slot_cnt` = 0, and its round-robin position does not move.
- R7: `ctx_grant` bit c is 1 exactly when some valid slot reports context c. No context is granted twice in a cycle, at most 4 bits are set, and the issue counts sum to at most 8.
- R8: All outputs are registered. They change only at a rising clock edge and reflect the inputs present at that edge.
- R9: A context that stays eligible is granted at least once in every 16 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ctx_ready | input | 64 | Per-context runnable flag (not stalled) |
| ins0_valid | input | 64 | Per-context first pending instruction valid |
| ins1_valid | input | 64 | Per-context second pending instruction valid |
| ins1_arith | input | 64 | Per-context second instruction is arithmetic |
| ins1_dep | input | 64 | Per-context second instruction depends on the first |
| slot_valid | output | 4 | Slot s issued from a context this cycle |
| slot_ctx | output | 24 | Chosen context number, 6 bits per slot |
| slot_cnt | output | 8 | Instructions issued, 2 bits per slot (0, 1 or 2) |
| ctx_grant | output | 64 | One-hot-per-slot issue acknowledge per context |

## Verification
The properties assume the per-context flags are stable, known values at each rising edge. They also assume the eligibility view latched at one edge is the one the grants of the next cycle answer to, so the flags must not change between the sampling edge and the decision. The fairness bound assumes a context's eligibility stays continuous; a context that drops out restarts its wait. The directed tasks change inputs only one time unit after an edge and hold them across the next edge. Eligibility patterns in the fairness run are held constant for the whole window, so every stimulus stays inside these assumptions.

// File: rtl/sched_pkg.sv
// Package: shared types and constants for the issue scheduler.
// Assumes context count and slot count are powers of two.
package sched_pkg;

    // Instructions issued by one slot in one cycle
    typedef logic [1:0] issue_cnt_t;

    localparam issue_cnt_t CNT_NONE = 2'd0;
    localparam issue_cnt_t CNT_ONE  = 2'd1;
    localparam issue_cnt_t CNT_TWO  = 2'd2;

endpackage

// File: rtl/grp_rr_pick.sv
// Round-robin picker over one group of contexts.
// Holds the search start position; the search begins there and wraps.
// After a grant the start moves one past the winner; with no eligible
// context it stays put. Assumes GROUP_SIZE is a power of two.
module grp_rr_pick #(
    parameter int GROUP_SIZE = 16,
    localparam int IDX_W = $clog2(GROUP_SIZE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GROUP_SIZE-1:0] elig,
    output logic                  found,
    output logic [IDX_W-1:0]      win_idx
);

    logic [IDX_W-1:0] start_q;

    // Search from start_q for the first eligible context
    always_comb begin
        logic [IDX_W-1:0] idx;
        found   = 1'b0;
        win_idx = '0;
        for (int i = 0; i < GROUP_SIZE; i++) begin
            idx = start_q + IDX_W'(i);
            if (!found && elig[idx]) begin
                found   = 1'b1;
                win_idx = idx;
            end
        end
    end

    // Move the start position past the winner
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (found)
            start_q <= win_idx + IDX_W'(1);
    end

endmodule

// File: rtl/pair_check.sv
// Dual-issue decision for the selected context of one slot.
// Pairs the second instruction only when it is valid, non-arithmetic
// and independent of the first. Assumes the first instruction is valid
// whenever found is set.
module pair_check
    import sched_pkg::*;
(
    input  logic       found,
    input  logic       sec_valid,
    input  logic       sec_arith,
    input  logic       sec_dep,
    output issue_cnt_t cnt
);

    // Choose 0, 1 or 2 instructions
    always_comb begin
        if (!found)
            cnt = CNT_NONE;
        else if (sec_valid && !sec_arith && !sec_dep)
            cnt = CNT_TWO;
        else
            cnt = CNT_ONE;
    end

endmodule

// File: rtl/issue_slot.sv
// One issue slot: picks a context from its fixed group, sizes the
// issue, and registers the slot outputs and the group acknowledge bits.
// Assumes the group of slot SLOT_IDX starts at context SLOT_IDX*GROUP_SIZE.
module issue_slot
    import sched_pkg::*;
#(
    parameter int GROUP_SIZE = 16,
    parameter int CTX_W      = 6,
    parameter int SLOT_IDX   = 0,
    localparam int IDX_W     = $clog2(GROUP_SIZE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GROUP_SIZE-1:0] ready,
    input  logic [GROUP_SIZE-1:0] first_valid,
    input  logic [GROUP_SIZE-1:0] sec_valid,
    input  logic [GROUP_SIZE-1:0] sec_arith,
    input  logic [GROUP_SIZE-1:0] sec_dep,
    output logic                  valid_q,
    output logic [CTX_W-1:0]      ctx_q,
    output issue_cnt_t            cnt_q,
    output logic [GROUP_SIZE-1:0] grant_q
);

    localparam logic [CTX_W-1:0] BASE = CTX_W'(SLOT_IDX * GROUP_SIZE);

    logic [GROUP_SIZE-1:0] elig;
    logic                  found;
    logic [IDX_W-1:0]      win_idx;
    issue_cnt_t            cnt_d;

    // Eligible means runnable with a valid first instruction
    assign elig = ready & first_valid;

    grp_rr_pick #(.GROUP_SIZE(GROUP_SIZE)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .found   (found),
        .win_idx (win_idx)
    );

    pair_check u_pair (
        .found     (found),
        .sec_valid (sec_valid[win_idx]),
        .sec_arith (sec_arith[win_idx]),
        .sec_dep   (sec_dep[win_idx]),
        .cnt       (cnt_d)
    );

    // Register the slot decision and its acknowledge bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ctx_q   <= '0;
            cnt_q   <= CNT_NONE;
            grant_q <= '0;
        end else begin
            valid_q <= found;
            ctx_q   <= found ? (BASE + CTX_W'(win_idx)) : '0;
            cnt_q   <= cnt_d;
            grant_q <= found ? (GROUP_SIZE'(1) << win_idx) : '0;
        end
    end

endmodule

// File: rtl/ctx_issue_sched.sv
// Top: per-clock issue selector over NUM_CTX contexts and NUM_SLOTS
// slots. Contexts are split evenly into one fixed group per slot, so
// no context can be chosen by two slots. Outputs are registered.
// Assumes NUM_CTX and NUM_SLOTS are powers of two, NUM_CTX >= 2*NUM_SLOTS.
module ctx_issue_sched
    import sched_pkg::*;
#(
    parameter int NUM_CTX   = 64,
    parameter int NUM_SLOTS = 4,
    localparam int CTX_W    = $clog2(NUM_CTX),
    localparam int GRP      = NUM_CTX / NUM_SLOTS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CTX-1:0]         ctx_ready,
    input  logic [NUM_CTX-1:0]         ins0_valid,
    input  logic [NUM_CTX-1:0]         ins1_valid,
    input  logic [NUM_CTX-1:0]         ins1_arith,
    input  logic [NUM_CTX-1:0]         ins1_dep,
    output logic [NUM_SLOTS-1:0]       slot_valid,
    output logic [NUM_SLOTS*CTX_W-1:0] slot_ctx,
    output logic [NUM_SLOTS*2-1:0]     slot_cnt,
    output logic [NUM_CTX-1:0]         ctx_grant
);

    // One slot per group of contexts
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        issue_cnt_t cnt_s;

        issue_slot #(
            .GROUP_SIZE (GRP),
            .CTX_W      (CTX_W),
            .SLOT_IDX   (s)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .ready       (ctx_ready [s*GRP +: GRP]),
            .first_valid (ins0_valid[s*GRP +: GRP]),
            .sec_valid   (ins1_valid[s*GRP +: GRP]),
            .sec_arith   (ins1_arith[s*GRP +: GRP]),
            .sec_dep     (ins1_dep  [s*GRP +: GRP]),
            .valid_q     (slot_valid[s]),
            .ctx_q       (slot_ctx[s*CTX_W +: CTX_W]),
            .cnt_q       (cnt_s),
            .grant_q     (ctx_grant[s*GRP +: GRP])
        );

        assign slot_cnt[s*2 +: 2] = cnt_s;
    end

endmodule

// File: rtl/sched_checker.sv
// Checker for ctx_issue_sched, attached by bind. Keeps its own delayed
// copy of eligibility and pairing conditions and a wait counter per
// context. Assumes inputs are stable around each rising edge.
module sched_checker #(
    parameter int NUM_CTX   = 64,
    parameter int NUM_SLOTS = 4,
    localparam int CTX_W    = $clog2(NUM_CTX),
    localparam int GRP      = NUM_CTX / NUM_SLOTS,
    localparam int IDX_W    = $clog2(GRP),
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CTX-1:0]         ctx_ready,
    input logic [NUM_CTX-1:0]         ins0_valid,
    input logic [NUM_CTX-1:0]         ins1_valid,
    input logic [NUM_CTX-1:0]         ins1_arith,
    input logic [NUM_CTX-1:0]         ins1_dep,
    input logic [NUM_SLOTS-1:0]       slot_valid,
    input logic [NUM_SLOTS*CTX_W-1:0] slot_ctx,
    input logic [NUM_SLOTS*2-1:0]     slot_cnt,
    input logic [NUM_CTX-1:0]         ctx_grant
);

    logic [NUM_CTX-1:0] elig_now, elig_q, pair_q;
    logic               rst_seen_q;
    int                 total;

    assign elig_now = ctx_ready & ins0_valid;

    // Remember last edge's view of the inputs
    always_ff @(posedge clk) begin
        rst_seen_q <= rst_n;
        elig_q     <= elig_now;
        pair_q     <= ins1_valid & ~ins1_arith & ~ins1_dep;
    end

    // Sum of issued instructions this cycle
    always_comb begin
        total = 0;
        for (int s = 0; s < NUM_SLOTS; s++)
            total = total + int'(slot_cnt[s*2 +: 2]);
    end

    // R7: acknowledge bits match the number of valid slots
    p_grant_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ctx_grant) == $countones(slot_valid));

    // R7: never more than two instructions per slot in total
    p_total_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        total <= 2 * NUM_SLOTS);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
        logic [CTX_W-1:0] cs;
        logic [1:0]       ns;
        assign cs = slot_ctx[s*CTX_W +: CTX_W];
        assign ns = slot_cnt[s*2 +: 2];

        // R2: a slot only reports contexts of its own group
        p_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] |-> (cs[IDX_W +: SLOT_W] == SLOT_W'(s)));

        // R6: idle slot issues nothing, busy slot issues something
        p_idle_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] ? (ns == 2'd1 || ns == 2'd2) : (ns == 2'd0));

        // R6: a group with an eligible context never leaves its slot idle
        p_no_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_seen_q && |elig_q[s*GRP +: GRP]) |-> slot_valid[s]);

        // R5: dual issue exactly when pairing was allowed
        p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] |-> ((ns == 2'd2) == pair_q[cs]));

        // R7: reported context has its acknowledge bit set
        p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_valid[s] |-> ctx_grant[cs]);
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx_chk
        logic [7:0] wait_q;

        // Count edges a context stays eligible without acknowledge
        always_ff @(posedge clk) begin
            if (!rst_n || !elig_now[c] || ctx_grant[c])
                wait_q <= '0;
            else if (wait_q != 8'hFF)
                wait_q <= wait_q + 8'd1;
        end

        // R3: only contexts eligible at the previous edge are granted
        p_elig_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_seen_q && ctx_grant[c]) |-> elig_q[c]);

        // R9: bounded wait for a continuously eligible context
        p_fair_r9: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q <= 8'(GRP + 1));
    end

endmodule

bind ctx_issue_sched sched_checker #(
    .NUM_CTX   (NUM_CTX),
    .NUM_SLOTS (NUM_SLOTS)
) u_chk (.*);

// File: tb/ctx_issue_sched_test.sv
// Directed bench for ctx_issue_sched with a requirement-level model of
// the per-group round-robin positions.
module ctx_issue_sched_test;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 64;
    localparam int NS = 4;
    localparam int G  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ready = '0, v0 = '0, v1 = '0, ar1 = '0, dep1 = '0;
    logic [NS-1:0]   slot_valid;
    logic [NS*6-1:0] slot_ctx;
    logic [NS*2-1:0] slot_cnt;
    logic [NC-1:0]   ctx_grant;

    int checks = 0;
    int fails  = 0;
    int mptr [NS];

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_issue_sched uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctx_ready  (ready),
        .ins0_valid (v0),
        .ins1_valid (v1),
        .ins1_arith (ar1),
        .ins1_dep   (dep1),
        .slot_valid (slot_valid),
        .slot_ctx   (slot_ctx),
        .slot_cnt   (slot_cnt),
        .ctx_grant  (ctx_grant)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: predict from current inputs, compare after the edge
    task automatic step(input string req);
        bit            ev [NS];
        int            ec [NS];
        int            en [NS];
        logic [NC-1:0] eg = '0;
        for (int s = 0; s < NS; s++) begin
            ev[s] = 0; ec[s] = 0; en[s] = 0;
            for (int i = 0; i < G; i++) begin
                int c = s*G + ((mptr[s] + i) % G);
                if (!ev[s] && ready[c] && v0[c]) begin
                    ev[s] = 1; ec[s] = c;
                end
            end
            if (ev[s]) begin
                en[s] = (v1[ec[s]] && !ar1[ec[s]] && !dep1[ec[s]]) ? 2 : 1;
                eg[ec[s]] = 1'b1;
            end
        end
        @(posedge clk); #1;
        for (int s = 0; s < NS; s++) begin
            chk(slot_valid[s] == ev[s], req, $sformatf("slot%0d valid", s),
                longint'(slot_valid[s]), longint'(ev[s]));
            chk(int'(slot_cnt[s*2 +: 2]) == en[s], req, $sformatf("slot%0d cnt", s),
                longint'(slot_cnt[s*2 +: 2]), longint'(en[s]));
            if (ev[s]) begin
                chk(int'(slot_ctx[s*6 +: 6]) == ec[s], req, $sformatf("slot%0d ctx", s),
                    longint'(slot_ctx[s*6 +: 6]), longint'(ec[s]));
                mptr[s] = ((ec[s] % G) + 1) % G;
            end
        end
        chk(ctx_grant == eg, req, "grant vector", longint'(ctx_grant), longint'(eg));
    endtask

    // R1: reset clears outputs and restarts each group at its first context
    task automatic t_reset();
        rst_n = 1'b0;
        ready = '1; v0 = '1; v1 = '1; ar1 = '0; dep1 = '0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk(slot_valid == '0, "R1", "valid in reset", longint'(slot_valid), 0);
        chk(slot_cnt == '0, "R1", "cnt in reset", longint'(slot_cnt), 0);
        chk(ctx_grant == '0, "R1", "grant in reset", longint'(ctx_grant), 0);
        rst_n = 1'b1;
        for (int s = 0; s < NS; s++) mptr[s] = 0;
        step("R1");
    endtask

    // R2 R4: rotation through full groups, second instruction arithmetic
    task automatic t_rotate();
        ready = '1; v0 = '1; v1 = '1; ar1 = '1; dep1 = '0;
        for (int k = 0; k < 20; k++) step("R4");
        step("R2");
    endtask

    // R3: stalled contexts and contexts with no valid first instruction
    task automatic t_skip();
        ready = 64'h00F0_0F00_8001_0011;
        v0    = 64'hFFFF_FFFF_FFFF_FF01;
        v1 = '0; ar1 = '0; dep1 = '0;
        for (int k = 0; k < 6; k++) step("R3");
        // R8: input change without an edge leaves outputs alone
        begin
            logic [NS*6-1:0] hold_ctx = slot_ctx;
            logic [NC-1:0]   hold_g   = ctx_grant;
            ready = '0;
            #2;
            chk(slot_ctx == hold_ctx, "R8", "ctx between edges",
                longint'(slot_ctx), longint'(hold_ctx));
            chk(ctx_grant == hold_g, "R8", "grant between edges",
                longint'(ctx_grant), longint'(hold_g));
        end
        step("R8");
    endtask

    // R5: each slot sees a different pairing condition
    task automatic t_dual();
        ready = '1; v0 = '1;
        v1   = {16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF};
        ar1  = {16'h0000, 16'h0000, 16'hFFFF, 16'h0000};
        dep1 = {16'h0000, 16'hFFFF, 16'h0000, 16'h0000};
        for (int k = 0; k < 3; k++) step("R5");
        chk(slot_cnt == 8'b01_01_01_10, "R5", "packed counts",
            longint'(slot_cnt), longint'(8'b01_01_01_10));
        ar1 = 64'h5555_5555_5555_5555; v1 = '1; dep1 = '0;
        for (int k = 0; k < 4; k++) step("R5");
    endtask

    // R6: empty group stays idle and keeps its position
    task automatic t_empty();
        ready = 64'hFFFF_0000_FFFF_FFFF; v0 = '1; v1 = '0; ar1 = '0; dep1 = '0;
        for (int k = 0; k < 3; k++) step("R6");
        ready = '1;
        step("R6");
    endtask

    // R9: every context of a full group is granted within 16 cycles
    task automatic t_fair();
        int hits [NC];
        ready = '1; v0 = '1; v1 = '1; ar1 = '0; dep1 = '0;
        for (int c = 0; c < NC; c++) hits[c] = 0;
        for (int k = 0; k < 16; k++) begin
            step("R9");
            for (int c = 0; c < NC; c++) if (ctx_grant[c]) hits[c]++;
        end
        for (int c = 0; c < NC; c++)
            chk(hits[c] >= 1, "R9", $sformatf("ctx%0d grants in 16", c),
                longint'(hits[c]), 1);
    endtask

    // R7: random mixes against the model, plus per-cycle bounds
    task automatic t_mixed();
        for (int k = 0; k < 150; k++) begin
            int sum = 0;
            ready = {$urandom, $urandom} & {$urandom, $urandom};
            v0    = ~({$urandom, $urandom} & {$urandom, $urandom});
            v1    = {$urandom, $urandom};
            ar1   = {$urandom, $urandom};
            dep1  = {$urandom, $urandom} & {$urandom, $urandom};
            step("R7");
            for (int s = 0; s < NS; s++) sum += int'(slot_cnt[s*2 +: 2]);
            chk($countones(ctx_grant) <= NS, "R7", "grant popcount",
                longint'($countones(ctx_grant)), NS);
            chk(sum <= 2*NS, "R7", "issued total", longint'(sum), 2*NS);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) mptr[s] = 0;
        t_reset();
        t_rotate();
        t_skip();
        t_dual();
        t_empty();
        t_fair();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule